// File: doc/BRIEF.md
# Gain Fade Ramp Sequencer

This controller owns the 5-bit gain step index of a stereo power amplifier, and it orders the power-up, shutdown entry and shutdown exit sequences. Every sequencing decision is taken on a one-cycle tick from a slow pacing clock. While a ramp runs, the gain moves by exactly one step every two ticks. A fade-mode input chooses what shutdown does. With fade enabled, the gain ramps down to the floor before the mid-supply bias is discharged, and on release it ramps back up once the bias is ready. With fade disabled, shutdown mutes at once and the gain jumps.

The analog side reports when the bias has reached mid-supply through a ready flag. The block answers with a charge/discharge command. It also drives the enables of the positive and negative output drivers and a mute flag, and it maps the step index to a nominal gain in dB. In single-ended operation that dB value is 6 dB lower. A 3-bit state output exposes the sequence position so that the ordering can be observed.

Top module: `gain_fade_seq`

## Requirements
- R1: After reset the block is in the charge state (`seq_state` code 1), with `gain_step` 0, `bias_charge` 1, `mute` 1 and both driver enables 0.
- R2: At power-up, once `bias_ready` is seen, the gain ramps from step 0 up to `target_step` (state code 2) and then enters the active state (code 3). This happens even when `fade_off` is 1.
- R3: During a ramp the gain changes by exactly one step every two ticks. The first step lands exactly two ticks after the ramp starts. On clock cycles without `tick`, neither the state nor the gain changes.
- R4: With `fade_off` 0, a tick that sees `shdn_n` low in the active state enters the ramp-down state (code 4). The gain then steps down to 0, and the next tick enters the discharge state (code 5).
- R5: `bias_charge` is 0 only in the discharge and off states, and only while `gain_step` is 0. The block moves from discharge to off (code 0) on a tick that sees `bias_ready` low.
- R6: With `fade_off` 0, releasing shutdown moves the block to the charge state. The gain is held until a tick sees `bias_ready`, then ramps up to the target and ends in the active state.
- R7: With `fade_off` 1, `mute` goes to 1 and both driver enables go to 0 in the same cycle that `shdn_n` falls. The next tick enters discharge with gain 0. On release, the first tick that sees `bias_ready` in the charge state jumps the gain straight to the target and enters the active state.
- R8: In the active state, a change of `target_step` is applied to `gain_step` at the next tick.
- R9: If shutdown is released during a ramp down, the next tick enters the charge state and keeps the current step. The ramp up then starts from that step.
- R10: `mute` is 1 in the off, charge and discharge states. `drv_pos_en` is the inverse of `mute`. `drv_neg_en` is 1 only when the block is not muted and `se_mode` is 0, so single-ended operation leaves the negative driver disabled.
- R11: `gain_db` is -85 for step 0. For step s > 0 it is 20 - 2*(31 - s) in bridge-tied mode, and 6 lower when `se_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| tick | input | 1 | One-cycle pulse from the slow pacing clock |
| shdn_n | input | 1 | Run request; low asks for shutdown |
| fade_off | input | 1 | 1 = jump/mute on shutdown, 0 = gradual ramps |
| se_mode | input | 1 | 1 = single-ended drive, 0 = bridge-tied drive |
| target_step | input | 5 | Quantized volume setting, step 0..31 |
| bias_ready | input | 1 | Mid-supply bias has settled |
| gain_step | output | 5 | Current gain step index |
| gain_db | output | 8 | Nominal gain in dB, signed |
| bias_charge | output | 1 | 1 = charge/hold bias, 0 = discharge toward ground |
| drv_pos_en | output | 1 | Positive output driver enable |
| drv_neg_en | output | 1 | Negative output driver enable |
| mute | output | 1 | Output muted |
| seq_state | output | 3 | Sequence position: 0 off, 1 charge, 2 ramp up, 3 active, 4 ramp down, 5 discharge |

## Verification
The bench builds the block with its default parameters: 5-bit steps, two ticks per step, and a dB map from -40 to 20 with a 6 dB single-ended drop. With these values the full 31-step fall from the top step, 62 ticks long, is short enough to be walked and counted tick by tick. The bench's bias model settles after three ticks. That makes the charge wait, the discharge-to-off exit and a ramp reversal part-way down all reachable within a few hundred ticks, and the exact first-step timing can be observed on every ramp.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_CHARGE  = 3'd1,
      ST_RAMP_UP = 3'd2,
      ST_ACTIVE  = 3'd3,
      ST_RAMP_DN = 3'd4,
      ST_DISCH   = 3'd5
   } seq_state_t;

endpackage

// File: rtl/gfs_pacer.sv
module gfs_pacer #(
   parameter int TICKS_PER_STEP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic due
);

   generate
      if (TICKS_PER_STEP < 1) begin : g_bad_rate
         $error("gfs_pacer: TICKS_PER_STEP must be at least 1");
      end

      if (TICKS_PER_STEP == 1) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign due = tick && !clr;
      end else begin : g_count
         localparam int CW = $clog2(TICKS_PER_STEP);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (clr)     cnt_q <= '0;
            else if (tick)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end

         assign due = tick && !clr && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/gfs_fsm.sv
module gfs_fsm
   import gfs_pkg::*;
#(
   parameter int STEP_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              due,
   input  logic              shdn_n,
   input  logic              fade_off,
   input  logic [STEP_W-1:0] target,
   input  logic              bias_ready,
   output seq_state_t        state,
   output logic [STEP_W-1:0] gain,
   output logic              pace_clr
);

   localparam logic [STEP_W-1:0] FLOOR = '0;

   seq_state_t        state_q, st_d;
   logic [STEP_W-1:0] gain_q, gain_d;
   logic              boot_q, boot_d;
   logic              at_floor, at_target, drop_now;

   assign at_floor  = (gain_q == FLOOR);
   assign at_target = (gain_q == target);
   // shutdown entry skips the ramp when fading is off or nothing is left to ramp
   assign drop_now  = fade_off || at_floor;

   always_comb begin
      st_d = state_q;
      if (tick) begin
         case (state_q)
            ST_OFF:     if (shdn_n) st_d = ST_CHARGE;
            ST_CHARGE: begin
               if (!shdn_n)         st_d = drop_now ? ST_DISCH : ST_RAMP_DN;
               else if (bias_ready) st_d = (fade_off && !boot_q) ? ST_ACTIVE : ST_RAMP_UP;
            end
            ST_RAMP_UP: begin
               if (!shdn_n)         st_d = drop_now ? ST_DISCH : ST_RAMP_DN;
               else if (at_target)  st_d = ST_ACTIVE;
            end
            ST_ACTIVE:  if (!shdn_n) st_d = drop_now ? ST_DISCH : ST_RAMP_DN;
            ST_RAMP_DN: begin
               if (shdn_n)          st_d = ST_CHARGE;
               else if (at_floor)   st_d = ST_DISCH;
            end
            ST_DISCH: begin
               if (shdn_n)          st_d = ST_CHARGE;
               else if (!bias_ready) st_d = ST_OFF;
            end
            default:                st_d = ST_OFF;
         endcase
      end
   end

   // the step pacer restarts whenever a ramp begins or changes direction
   assign pace_clr = !(state_q == ST_RAMP_UP || state_q == ST_RAMP_DN) || (st_d != state_q);

   always_comb begin
      gain_d = gain_q;
      if (tick) begin
         case (state_q)
            ST_CHARGE: begin
               if (!shdn_n) begin
                  if (fade_off) gain_d = FLOOR;
               end else if (bias_ready && fade_off && !boot_q) begin
                  gain_d = target;
               end
            end
            ST_RAMP_UP: begin
               if (!shdn_n) begin
                  if (fade_off) gain_d = FLOOR;
               end else if (!at_target && due) begin
                  gain_d = (gain_q < target) ? gain_q + 1'b1 : gain_q - 1'b1;
               end
            end
            ST_ACTIVE: begin
               if (!shdn_n) begin
                  if (fade_off) gain_d = FLOOR;
               end else begin
                  gain_d = target;
               end
            end
            ST_RAMP_DN: if (!shdn_n && !at_floor && due) gain_d = gain_q - 1'b1;
            ST_OFF, ST_DISCH: gain_d = FLOOR;
            default:          gain_d = FLOOR;
         endcase
      end
   end

   assign boot_d = boot_q && !(st_d == ST_ACTIVE || st_d == ST_RAMP_DN || st_d == ST_DISCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_CHARGE;
         gain_q  <= FLOOR;
         boot_q  <= 1'b1;
      end else begin
         state_q <= st_d;
         gain_q  <= gain_d;
         boot_q  <= boot_d;
      end
   end

   assign state = state_q;
   assign gain  = gain_q;

   AST_DISCH_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DISCH || state_q == ST_OFF) |-> (gain_q == FLOOR)); // R5
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RAMP_UP || state_q == ST_RAMP_DN) && $past(state_q) == state_q)
      |-> (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1 || gain_q == $past(gain_q) - 1'b1)); // R3
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> ($stable(state_q) && $stable(gain_q))); // R3
   AST_RAMP_AFTER_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RAMP_UP && $past(state_q) == ST_CHARGE) |-> $past(bias_ready)); // R6

endmodule

// File: rtl/gfs_drive.sv
module gfs_drive
   import gfs_pkg::*;
#(
   parameter int STEP_W     = 5,
   parameter int DB_W       = 8,
   parameter int MUTE_DB    = -85,
   parameter int TOP_DB     = 20,
   parameter int STEP_DB    = 2,
   parameter int SE_DROP_DB = 6
) (
   input  seq_state_t               state,
   input  logic                     shdn_n,
   input  logic                     fade_off,
   input  logic                     se_mode,
   input  logic [STEP_W-1:0]        gain,
   output logic                     bias_charge,
   output logic                     mute,
   output logic                     pos_en,
   output logic                     neg_en,
   output logic signed [DB_W-1:0]   gain_db
);

   localparam int MAX_STEP = (1 << STEP_W) - 1;
   localparam int LOW_DB   = TOP_DB - STEP_DB * (MAX_STEP - 1) - SE_DROP_DB;

   generate
      if (LOW_DB <= MUTE_DB) begin : g_bad_map
         $error("gfs_drive: lowest audible step must sit above the mute level");
      end
      if (TOP_DB >= (1 << (DB_W - 1)) || MUTE_DB < -(1 << (DB_W - 1))) begin : g_bad_width
         $error("gfs_drive: DB_W too narrow for the dB range");
      end
   endgenerate

   logic quiet;
   assign quiet       = (state == ST_OFF) || (state == ST_CHARGE) || (state == ST_DISCH);
   assign bias_charge = !((state == ST_OFF) || (state == ST_DISCH));
   assign mute        = quiet || (!shdn_n && fade_off);
   assign pos_en      = !mute;
   assign neg_en      = !mute && !se_mode;

   int base_db, mode_db;
   assign base_db = TOP_DB - STEP_DB * (MAX_STEP - int'(gain));

   generate
      if (SE_DROP_DB == 0) begin : g_flat
         assign mode_db = base_db;
      end else begin : g_se_drop
         assign mode_db = se_mode ? base_db - SE_DROP_DB : base_db;
      end
   endgenerate

   assign gain_db = (gain == '0) ? DB_W'(MUTE_DB) : DB_W'(mode_db);

endmodule

// File: rtl/gain_fade_seq.sv
module gain_fade_seq
   import gfs_pkg::*;
#(
   parameter int STEP_W         = 5,
   parameter int TICKS_PER_STEP = 2,
   parameter int DB_W           = 8,
   parameter int MUTE_DB        = -85,
   parameter int TOP_DB         = 20,
   parameter int STEP_DB        = 2,
   parameter int SE_DROP_DB     = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   shdn_n,
   input  logic                   fade_off,
   input  logic                   se_mode,
   input  logic [STEP_W-1:0]      target_step,
   input  logic                   bias_ready,
   output logic [STEP_W-1:0]      gain_step,
   output logic signed [DB_W-1:0] gain_db,
   output logic                   bias_charge,
   output logic                   drv_pos_en,
   output logic                   drv_neg_en,
   output logic                   mute,
   output logic [2:0]             seq_state
);

   generate
      if (STEP_W < 2 || STEP_W > 8) begin : g_bad_step_w
         $error("gain_fade_seq: STEP_W must be in 2..8");
      end
   endgenerate

   seq_state_t state;
   logic       due, pace_clr;

   gfs_pacer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (pace_clr),
      .due   (due)
   );

   gfs_fsm #(.STEP_W(STEP_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .due        (due),
      .shdn_n     (shdn_n),
      .fade_off   (fade_off),
      .target     (target_step),
      .bias_ready (bias_ready),
      .state      (state),
      .gain       (gain_step),
      .pace_clr   (pace_clr)
   );

   gfs_drive #(
      .STEP_W     (STEP_W),
      .DB_W       (DB_W),
      .MUTE_DB    (MUTE_DB),
      .TOP_DB     (TOP_DB),
      .STEP_DB    (STEP_DB),
      .SE_DROP_DB (SE_DROP_DB)
   ) u_drive (
      .state       (state),
      .shdn_n      (shdn_n),
      .fade_off    (fade_off),
      .se_mode     (se_mode),
      .gain        (gain_step),
      .bias_charge (bias_charge),
      .mute        (mute),
      .pos_en      (drv_pos_en),
      .neg_en      (drv_neg_en),
      .gain_db     (gain_db)
   );

   assign seq_state = state;

   AST_SE_NEG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      se_mode |-> !drv_neg_en); // R10
   AST_FADEOFF_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!shdn_n && fade_off) |-> (mute && !drv_pos_en && !drv_neg_en)); // R7
   AST_DISCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !bias_charge |-> (gain_step == '0 && mute)); // R5

endmodule

// File: tb/gain_fade_seq_bench.sv
`timescale 1ns/100ps
module gain_fade_seq_bench;

   localparam int BIAS_DLY = 3;
   localparam int ST_OFF = 0, ST_CHG = 1, ST_UP = 2, ST_ACT = 3, ST_DN = 4, ST_DIS = 5;

   typedef struct packed {
      logic [4:0]        tgt;
      logic              se;
      logic signed [7:0] db;
      logic              neg;
   } vec_t;

   localparam vec_t VECS [0:7] = '{
      '{5'd31, 1'b0,  8'sd20, 1'b1},
      '{5'd31, 1'b1,  8'sd14, 1'b0},
      '{5'd1,  1'b0, -8'sd40, 1'b1},
      '{5'd1,  1'b1, -8'sd46, 1'b0},
      '{5'd0,  1'b0, -8'sd85, 1'b1},
      '{5'd0,  1'b1, -8'sd85, 1'b0},
      '{5'd16, 1'b0, -8'sd10, 1'b1},
      '{5'd20, 1'b1, -8'sd8,  1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic shdn_n = 1'b1;
   logic fade_off = 1'b1;
   logic se_mode = 1'b0;
   logic [4:0] target_step = 5'd5;
   logic bias_ready;
   logic [4:0] gain_step;
   logic signed [7:0] gain_db;
   logic bias_charge, drv_pos_en, drv_neg_en, mute;
   logic [2:0] seq_state;

   int n_tests = 0;
   int n_fail = 0;
   int bias_lvl = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gain_fade_seq u_gain_fade_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .shdn_n      (shdn_n),
      .fade_off    (fade_off),
      .se_mode     (se_mode),
      .target_step (target_step),
      .bias_ready  (bias_ready),
      .gain_step   (gain_step),
      .gain_db     (gain_db),
      .bias_charge (bias_charge),
      .drv_pos_en  (drv_pos_en),
      .drv_neg_en  (drv_neg_en),
      .mute        (mute),
      .seq_state   (seq_state)
   );

   // bias model: settles BIAS_DLY ticks after charging starts
   always @(posedge clk) begin
      if (!rst_n) bias_lvl <= 0;
      else if (tick) begin
         if (bias_charge && bias_lvl < BIAS_DLY)       bias_lvl <= bias_lvl + 1;
         else if (!bias_charge && bias_lvl > 0)        bias_lvl <= bias_lvl - 1;
      end
   end
   assign bias_ready = (bias_lvl == BIAS_DLY);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic tick_while_state(input int st, input int limit);
      for (int i = 0; i < limit && int'(seq_state) == st; i++) do_tick();
   endtask

   // ticks until gain reaches goal; returns the count
   task automatic ticks_to_gain(input int goal, output int n);
      n = 0;
      while (int'(gain_step) != goal && n < 200) begin
         do_tick();
         n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(seq_state == 3'(ST_CHG), "R1 state", seq_state, ST_CHG);
      chk(gain_step == 0, "R1 gain", gain_step, 0);
      chk(bias_charge && mute && !drv_pos_en && !drv_neg_en, "R1 outputs",
          {bias_charge, mute, drv_pos_en, drv_neg_en}, 4'b1100);

      // R2 power-up ramps even with fade_off = 1
      tick_while_state(ST_CHG, 20);
      chk(seq_state == 3'(ST_UP), "R2 ramp after bias", seq_state, ST_UP);
      chk(gain_step == 0, "R2 ramp starts at floor", gain_step, 0);
      do_tick();
      chk(gain_step == 0, "R3 no step after one tick", gain_step, 0);
      do_tick();
      chk(gain_step == 1, "R3 first step at second tick", gain_step, 1);
      ticks_to_gain(5, n);
      chk(n == 8, "R3 two ticks per step", n, 8);
      do_tick();
      chk(seq_state == 3'(ST_ACT), "R2 active after ramp", seq_state, ST_ACT);

      // R3 no change without tick
      target_step = 5'd9;
      repeat (6) @(negedge clk);
      chk(gain_step == 5 && seq_state == 3'(ST_ACT), "R3 hold without tick", gain_step, 5);

      // R8 R10 R11 vector walk in the active state
      foreach (VECS[i]) begin
         target_step = VECS[i].tgt;
         se_mode     = VECS[i].se;
         do_tick();
         chk(gain_step == VECS[i].tgt, "R8 direct target", gain_step, VECS[i].tgt);
         chk(gain_db == VECS[i].db, "R11 dB map", gain_db, VECS[i].db);
         chk(drv_neg_en == VECS[i].neg && drv_pos_en && !mute, "R10 drivers",
             {drv_pos_en, drv_neg_en}, {1'b1, VECS[i].neg});
      end

      // R4 R5 fade-on shutdown from the top step
      se_mode = 1'b0;
      target_step = 5'd31;
      do_tick();
      fade_off = 1'b0;
      shdn_n = 1'b0;
      @(negedge clk);
      chk(!mute && drv_pos_en, "R4 no mute before ramp", mute, 0);
      do_tick();
      chk(seq_state == 3'(ST_DN) && gain_step == 31, "R4 ramp down entered", seq_state, ST_DN);
      n = 0;
      while (gain_step != 0 && n < 200) begin
         do_tick();
         n++;
         if (!bias_charge) chk(1'b0, "R5 discharge before floor", gain_step, 0);
      end
      chk(n == 62, "R4 full ramp length", n, 62);
      chk(seq_state == 3'(ST_DN), "R5 still ramping at floor", seq_state, ST_DN);
      do_tick();
      chk(seq_state == 3'(ST_DIS) && !bias_charge && mute, "R5 discharge after floor", seq_state, ST_DIS);
      tick_while_state(ST_DIS, 20);
      chk(seq_state == 3'(ST_OFF) && gain_step == 0, "R5 off after bias low", seq_state, ST_OFF);

      // R6 fade-on release
      target_step = 5'd10;
      shdn_n = 1'b1;
      do_tick();
      chk(seq_state == 3'(ST_CHG) && bias_charge, "R6 charge on release", seq_state, ST_CHG);
      n = 0;
      while (seq_state == 3'(ST_CHG) && n < 20) begin
         if (gain_step != 0) chk(1'b0, "R6 gain held in charge", gain_step, 0);
         do_tick();
         n++;
      end
      chk(seq_state == 3'(ST_UP) && gain_step == 0, "R6 ramp up after bias", seq_state, ST_UP);
      ticks_to_gain(10, n);
      chk(n == 20, "R6 ramp length", n, 20);
      do_tick();
      chk(seq_state == 3'(ST_ACT), "R6 active", seq_state, ST_ACT);

      // R9 reversal part-way down
      shdn_n = 1'b0;
      do_tick();
      repeat (4) do_tick();
      chk(gain_step == 8 && seq_state == 3'(ST_DN), "R9 two steps down", gain_step, 8);
      shdn_n = 1'b1;
      do_tick();
      chk(seq_state == 3'(ST_CHG) && gain_step == 8, "R9 charge keeps step", gain_step, 8);
      do_tick();
      chk(seq_state == 3'(ST_UP) && gain_step == 8, "R9 ramp from current step", seq_state, ST_UP);
      ticks_to_gain(10, n);
      chk(n == 4, "R9 ramp back up", n, 4);

      // R7 fade-off shutdown and release
      do_tick();
      fade_off = 1'b1;
      shdn_n = 1'b0;
      #1;
      chk(mute && !drv_pos_en && !drv_neg_en, "R7 immediate mute",
          {mute, drv_pos_en, drv_neg_en}, 3'b100);
      @(negedge clk);
      do_tick();
      chk(seq_state == 3'(ST_DIS) && gain_step == 0, "R7 discharge at once", seq_state, ST_DIS);
      tick_while_state(ST_DIS, 20);
      shdn_n = 1'b1;
      do_tick();
      chk(seq_state == 3'(ST_CHG), "R7 charge on release", seq_state, ST_CHG);
      tick_while_state(ST_CHG, 20);
      chk(seq_state == 3'(ST_ACT) && gain_step == 10, "R7 jump to target", gain_step, 10);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule